// File: doc/BRIEF.md
# Display Timing Dot-Phase Adjuster

This block re-aligns an externally generated display-enable signal against a stream of pixel data arriving at the dot rate. Because the enable and the pixel data reach the block through different paths with different lags, the enable can lead or trail the first active pixel of a line by a few dots. The block moves the enable by a signed number of whole dots so that its edges coincide with the active pixels again.

The shift is set by a sign-magnitude code of one direction bit above a magnitude field. The code comes either from a set of adjust pins or from a writable fine-adjust register, and a mode input picks the source. To make an early shift possible, the pixel data always passes through a fixed delay of the maximum magnitude plus one output register. The enable passes through a delay that is longer or shorter than that by the selected shift. It is taken from a tapped shift line with twice the maximum magnitude plus one taps.

Top module: `dot_phase_adjust`

## Requirements
- R1: The adjust code is MAG_W+1 bits wide: the top bit gives the direction and the low MAG_W bits give the magnitude in dots, 0 to 2**MAG_W-1 (7 by default).
- R2: With the direction bit at 1 and magnitude m, each edge of `timing_out` comes m dot clocks later than the matching pixel edge on `pix_out` (code 1010 gives +2).
- R3: With the direction bit at 0 and magnitude m, each edge of `timing_out` comes m dot clocks earlier than the matching pixel edge on `pix_out` (code 0010 gives -2).
- R4: A magnitude of zero gives no shift, whatever the direction bit (0000 and 1000 behave the same).
- R5: With `use_pins` at 1 the code is taken from `adj_pins`; with `use_pins` at 0 it is taken from the fine-adjust register, and the pins have no effect.
- R6: A write with `wr_en` high loads `wr_code` into the register on that clock edge, and the new code steers the output from the next edge on. Without a write the register holds its value.
- R7: `pix_out` equals `pix_in` delayed by exactly 2**MAG_W dot clocks (8 by default), whatever the code.
- R8: Reset clears the register to 0000 and both delay lines and outputs to zero. After reset `timing_out` stays low until a high input has travelled through the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| timing_in | input | 1 | Raw display-enable signal |
| pix_in | input | DATA_W | Pixel data at the dot rate |
| adj_pins | input | MAG_W+1 | Adjust code from pins (top bit: direction) |
| use_pins | input | 1 | 1: code from pins, 0: code from register |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | MAG_W+1 | Code written to the fine-adjust register |
| timing_out | output | 1 | Re-aligned display enable |
| pix_out | output | DATA_W | Pixel data matched to `timing_out` |

## Verification
The bench builds the block with its defaults, MAG_W=3 and DATA_W=8. With these values all sixteen codes can be tried in both source modes, and both ends of the enable line are reached: a delay of one dot for -7 and fifteen dots for +7. The 8-bit data width lets each pixel carry its own position, so the first and last valid pixel at the output are easy to find.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  // Meaning of the top bit of the adjust code
  typedef enum logic {
    DIR_EARLY = 1'b0,
    DIR_LATE  = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/dpa_code_src.sv
module dpa_code_src
  import dpa_pkg::*;
#(
  parameter int MAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_pins,
  input  logic [MAG_W:0]   adj_pins,
  input  logic             wr_en,
  input  logic [MAG_W:0]   wr_code,
  output shift_dir_e       dir,
  output logic [MAG_W-1:0] mag
);
  logic [MAG_W:0] fine_reg;
  logic [MAG_W:0] active;

  always_ff @(posedge clk) begin
    if (rst)        fine_reg <= '0;
    else if (wr_en) fine_reg <= wr_code;
  end

  assign active = use_pins ? adj_pins : fine_reg;
  assign dir    = shift_dir_e'(active[MAG_W]);
  assign mag    = active[MAG_W-1:0];

  // R6: a write lands in the register on its edge
  p_reg_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (fine_reg == $past(wr_code)));

  // R6: without a write the register keeps its value
  p_reg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(fine_reg));
endmodule

// File: rtl/dpa_tap_line.sv
module dpa_tap_line #(
  parameter int W     = 1,
  parameter int TAPS  = 15,
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [TAPS-1];
  logic [W-1:0] tap   [TAPS];
  logic         any_nz;

  assign tap[0] = din;
  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    assign tap[g] = stage[g-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS-1; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < TAPS-1; k++) stage[k] <= stage[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   dout <= '0;
    else if (32'(sel) < TAPS)  dout <= tap[sel];
    else                       dout <= '0;
  end

  always_comb begin
    any_nz = 1'b0;
    for (int k = 0; k < TAPS; k++) any_nz = any_nz | (tap[k] != '0);
  end

  // R1: the selected tap always lies inside the line
  p_sel_range_r1: assert property (@(posedge clk) disable iff (rst)
    32'(sel) < TAPS);

  // R7: nothing appears at the output that was not in the line
  p_no_phantom_r7: assert property (@(posedge clk) disable iff (rst)
    (dout != '0) |-> $past(any_nz));
endmodule

// File: rtl/dot_phase_adjust.sv
module dot_phase_adjust
  import dpa_pkg::*;
#(
  parameter int MAG_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timing_in,
  input  logic [DATA_W-1:0] pix_in,
  input  logic [MAG_W:0]    adj_pins,
  input  logic              use_pins,
  input  logic              wr_en,
  input  logic [MAG_W:0]    wr_code,
  output logic              timing_out,
  output logic [DATA_W-1:0] pix_out
);
  localparam int MAX_SHIFT = (1 << MAG_W) - 1;
  localparam int T_TAPS    = 2 * MAX_SHIFT + 1;
  localparam int D_TAPS    = MAX_SHIFT + 1;
  localparam int T_SEL_W   = $clog2(T_TAPS);
  localparam int D_SEL_W   = (D_TAPS > 1) ? $clog2(D_TAPS) : 1;

  shift_dir_e         dir;
  logic [MAG_W-1:0]   mag;
  logic [T_SEL_W-1:0] t_sel;
  logic [D_SEL_W-1:0] d_sel;

  dpa_code_src #(.MAG_W(MAG_W)) u_code (
    .clk(clk), .rst(rst), .use_pins(use_pins), .adj_pins(adj_pins),
    .wr_en(wr_en), .wr_code(wr_code), .dir(dir), .mag(mag)
  );

  // Centre tap equals the data delay; the shift moves around it
  always_comb begin
    if (dir == DIR_LATE) t_sel = T_SEL_W'(MAX_SHIFT) + T_SEL_W'(mag);
    else                 t_sel = T_SEL_W'(MAX_SHIFT) - T_SEL_W'(mag);
  end
  assign d_sel = D_SEL_W'(MAX_SHIFT);

  dpa_tap_line #(.W(1), .TAPS(T_TAPS)) u_timing_line (
    .clk(clk), .rst(rst), .din(timing_in), .sel(t_sel), .dout(timing_out)
  );

  dpa_tap_line #(.W(DATA_W), .TAPS(D_TAPS)) u_pix_line (
    .clk(clk), .rst(rst), .din(pix_in), .sel(d_sel), .dout(pix_out)
  );

  // R8: a reset cycle leaves both outputs cleared
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!timing_out && pix_out == '0));
endmodule

// File: tb/dot_phase_adjust_bench.sv
module dot_phase_adjust_bench;
  localparam int CLK_NS = 4;
  localparam int MAG_W  = 3;
  localparam int DATA_W = 8;
  localparam int LAT    = 8;  // 2**MAG_W
  localparam int T_ON   = 10;
  localparam int T_LEN  = 20;

  // code, expected shift of timing relative to pixels
  localparam logic [3:0] CODE [16] = '{4'h0,4'h1,4'h2,4'h3,4'h4,4'h5,4'h6,4'h7,
                                       4'h8,4'h9,4'hA,4'hB,4'hC,4'hD,4'hE,4'hF};
  localparam int EXP_OFF [16] = '{0,-1,-2,-3,-4,-5,-6,-7,0,1,2,3,4,5,6,7};

  logic clk = 1'b0;
  logic rst, timing_in, use_pins, wr_en, timing_out;
  logic [DATA_W-1:0] pix_in, pix_out;
  logic [MAG_W:0] adj_pins, wr_code;
  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  dot_phase_adjust #(.MAG_W(MAG_W), .DATA_W(DATA_W)) u_dot_phase_adjust (
    .clk(clk), .rst(rst), .timing_in(timing_in), .pix_in(pix_in),
    .adj_pins(adj_pins), .use_pins(use_pins), .wr_en(wr_en), .wr_code(wr_code),
    .timing_out(timing_out), .pix_out(pix_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      timing_in = 1'b0; pix_in = '0; wr_en = 1'b0;
    end
  endtask

  task automatic write_reg(input logic [3:0] c);
    @(negedge clk); wr_en = 1'b1; wr_code = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // One line: enable high T_ON..T_ON+T_LEN-1, pixels numbered while active
  task automatic run_line(input int idx, input bit pins);
    int first_pix = -1, last_pix = -1, rise = -1, last_hi = -1;
    string tag;
    if (EXP_OFF[idx] == 0)     tag = "R4";
    else if (EXP_OFF[idx] > 0) tag = "R2";
    else                       tag = "R3";
    tag = {tag, pins ? "/R5 pins" : "/R5 register"};
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (pix_out != '0) begin
        if (first_pix < 0) first_pix = n;
        last_pix = n;
      end
      if (timing_out) begin
        if (rise < 0) rise = n;
        last_hi = n;
      end
      timing_in = (n >= T_ON && n < T_ON + T_LEN);
      pix_in    = timing_in ? DATA_W'(n - T_ON + 1) : '0;
    end
    check("R7 pixel latency", first_pix, T_ON + LAT);
    check({tag, " leading edge"},  rise - first_pix, EXP_OFF[idx]);
    check({tag, " trailing edge"}, last_hi - last_pix, EXP_OFF[idx]);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; timing_in = 1'b1; pix_in = 8'hA5; use_pins = 1'b0;
    adj_pins = 4'hF; wr_en = 1'b0; wr_code = '0;
    repeat (4) @(negedge clk);
    check("R8 timing_out in reset", int'(timing_out), 0);
    check("R8 pix_out in reset", int'(pix_out), 0);

    // R8: register cleared to 0000, pins ignored, line fills in LAT edges
    rst = 1'b0;
    for (int n = 0; n <= LAT; n++) begin
      if (n == LAT - 1) check("R8 still low before fill", int'(timing_out), 0);
      if (n == LAT)     check("R8 high after fill", int'(timing_out), 1);
      if (n < LAT) @(negedge clk);
    end
    idle(20);
    run_line(0, 1'b0);  // register reset value gives zero shift

    // Table walk: every code through both sources
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        if (m == 1) begin
          use_pins = 1'b1; adj_pins = CODE[i];
          write_reg(~CODE[i]);
        end else begin
          use_pins = 1'b0; adj_pins = ~CODE[i];
          write_reg(CODE[i]);
        end
        idle(20);
        run_line(i, m == 1);
      end
    end

    // R6: new code steers the very next edge
    use_pins = 1'b0;
    write_reg(4'h0);
    idle(20);
    @(negedge clk); timing_in = 1'b1;
    idle(0);
    for (int n = 0; n < 6; n++) @(negedge clk);   // input high for 6 edges so far
    wr_en = 1'b1; wr_code = 4'h2;                  // advance by two: tap 5
    @(negedge clk); wr_en = 1'b0;                  // register loaded on this edge
    check("R6 old code before switch", int'(timing_out), 0);
    @(negedge clk);                                // tap 5 sampled: input was high
    check("R6 new code next edge", int'(timing_out), 1);
    timing_in = 1'b0;
    idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule